// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four modem handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchroniser into the clock domain. The block keeps a sticky change flag for every line. Software reads the current levels and the change flags from a status register, and clears flags by writing ones to them. While any flag is set, a single event output tells the interrupt logic that the modem status has changed. The ring indicator is treated differently from the other lines: only its falling edge, from asserted to deasserted, raises its flag.

The same block holds the modem control register. Its data-terminal-ready and request-to-send bits drive active-low pins, and its automatic flow control enable drives a level output. The status register also carries one plain read/write flow mode bit.

A small state machine keeps flags from being set by power-up values. It has two states. WARMUP is entered on reset and lasts SYNC_STAGES+1 clocks, until the synchroniser and the previous-level register hold real input values; no flag can be set in this state. ARMED follows and is held until the next reset; edge detection is live in this state. The only transition is WARMUP to ARMED, taken when the warm-up counter reaches SYNC_STAGES.

Top module: `msd_modem_status`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, dtr_n and rts_n are 1, and flow_en and msc_irq are 0.
- R2: Control register at offset 0x24. Bit 0 is DTR, bit 1 is RTS and bit 5 is the flow control enable. These bits read back the last value written, and all other bits read 0.
- R3: After the clock edge that writes the control register, dtr_n is the inverse of bit 0, rts_n is the inverse of bit 1, and flow_en equals bit 5.
- R4: Status register at offset 0x28. Bit 8 is a read/write flow mode bit. Bits 7, 6, 5 and 4 read the synchronised DCD, RI, DSR and CTS levels, which change two clock edges after the input changes. Writes to bits 7 to 4 have no effect.
- R5: A change of CTS, DSR or DCD in either direction sets status bit 0, 1 or 3 respectively, on the third clock edge after the input changes.
- R6: A falling RI (1 to 0) sets status bit 2; a rising RI sets no flag.
- R7: Writing 1 to a flag bit (bits 3 to 0) of the status register clears it. Writing 0 leaves it unchanged.
- R8: If a flag is set and cleared in the same clock, it ends set.
- R9: msc_irq is high exactly while at least one flag bit is set.
- R10: During the SYNC_STAGES+1 clocks after reset, input levels present at reset set no flag.
- R11: Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| cts_in | input | 1 | Clear-to-send level, asynchronous |
| dsr_in | input | 1 | Data-set-ready level, asynchronous |
| ri_in | input | 1 | Ring indicator level, asynchronous |
| dcd_in | input | 1 | Carrier detect level, asynchronous |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| flow_en | output | 1 | Automatic flow control enable |
| msc_irq | output | 1 | Modem status change event |

## Verification
A register write takes effect on the clock edge that samples it, so control readback and pin values are checked at the falling edge that follows. An input change shows up in the level bits after two rising edges and in the flag bits after three. The bench drives inputs at a falling edge and checks both sides of each boundary: the flag is still clear after two edges and set after three. The set-versus-clear collision is timed so that the write lands on that third edge. Randomised rounds wait four edges before comparing against the bench's model, so they never sample inside the synchroniser latency.

// File: rtl/msd_pkg.sv
package msd_pkg;
    // line index doubles as flag bit position and (plus 4) level bit position
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;
    localparam int NUM_LINES = 4;

    localparam int OFS_CTRL   = 'h24;
    localparam int OFS_STATUS = 'h28;

    localparam int CTRL_DTR_BIT  = 0;
    localparam int CTRL_RTS_BIT  = 1;
    localparam int CTRL_AFC_BIT  = 5;
    localparam int STAT_FLOW_BIT = 8;
    localparam int STAT_LVL_LSB  = 4;

    typedef enum logic [0:0] {
        ST_WARMUP = 1'b0,
        ST_ARMED  = 1'b1
    } arm_state_t;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/msd_delta.sv
module msd_delta
    import msd_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int STAGES = 2,
    parameter int RI_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    input  logic [LINES-1:0] clr_mask,
    output logic [LINES-1:0] delta
);
    localparam int CNT_W     = $clog2(STAGES + 1) + 1;
    localparam int WARM_LAST = STAGES;

    arm_state_t       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] delta_q;
    logic [LINES-1:0] ev;
    logic             armed;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_WARMUP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        unique case (st_q)
            ST_WARMUP: begin
                if (cnt_q == CNT_W'(WARM_LAST)) st_nx = ST_ARMED;
                else                            cnt_nx = cnt_q + 1'b1;
            end
            ST_ARMED: st_nx = ST_ARMED;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        armed = 1'b0;
        unique case (st_q)
            ST_WARMUP: armed = 1'b0;
            ST_ARMED:  armed = 1'b1;
        endcase
    end

    for (genvar i = 0; i < LINES; i++) begin : g_ev
        if (i == RI_IDX) begin : g_trail
            assign ev[i] = armed & prev_q[i] & ~lvl[i];
        end else begin : g_any
            assign ev[i] = armed & (prev_q[i] ^ lvl[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            delta_q <= '0;
        end else begin
            prev_q  <= lvl;
            delta_q <= (delta_q & ~clr_mask) | ev;
        end
    end

    assign delta = delta_q;

    // R7: a flag only drops on a clock where software wrote one to it
    assert_clear_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(delta_q) & ~delta_q) & ~$past(clr_mask)) == '0));

    // R6: the ring flag rises only after an asserted-to-deasserted step
    assert_ri_trailing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[RI_IDX]) |-> ($past(prev_q[RI_IDX]) && !$past(lvl[RI_IDX])));

    // R10: nothing can be flagged before the chain holds real samples
    assert_quiet_warmup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WARMUP) |-> (delta_q == '0));
endmodule

// File: rtl/msd_modem_status.sv
module msd_modem_status
    import msd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              ri_in,
    input  logic              dcd_in,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              flow_en,
    output logic              msc_irq
);
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] sync_lines;
    logic [NUM_LINES-1:0] delta;
    logic [NUM_LINES-1:0] clr_mask;
    logic                 wr_ctrl, wr_stat;
    logic                 dtr_q, rts_q, afc_q, flow_mode_q;
    logic                 wr_unused;

    always_comb begin
        raw_lines         = '0;
        raw_lines[LN_CTS] = cts_in;
        raw_lines[LN_DSR] = dsr_in;
        raw_lines[LN_RI]  = ri_in;
        raw_lines[LN_DCD] = dcd_in;
    end

    msd_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines),
        .dout  (sync_lines)
    );

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat  = wr_en && (wr_addr == ADDR_W'(OFS_STATUS));
    assign clr_mask = wr_stat ? wr_data[NUM_LINES-1:0] : '0;

    msd_delta #(
        .LINES  (NUM_LINES),
        .STAGES (SYNC_STAGES),
        .RI_IDX (LN_RI)
    ) u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (sync_lines),
        .clr_mask (clr_mask),
        .delta    (delta)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtr_q       <= 1'b0;
            rts_q       <= 1'b0;
            afc_q       <= 1'b0;
            flow_mode_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                dtr_q <= wr_data[CTRL_DTR_BIT];
                rts_q <= wr_data[CTRL_RTS_BIT];
                afc_q <= wr_data[CTRL_AFC_BIT];
            end
            if (wr_stat) flow_mode_q <= wr_data[STAT_FLOW_BIT];
        end
    end

    assign dtr_n   = ~dtr_q;
    assign rts_n   = ~rts_q;
    assign flow_en = afc_q;
    assign msc_irq = |delta;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_CTRL)) begin
            rd_data[CTRL_DTR_BIT] = dtr_q;
            rd_data[CTRL_RTS_BIT] = rts_q;
            rd_data[CTRL_AFC_BIT] = afc_q;
        end else if (rd_addr == ADDR_W'(OFS_STATUS)) begin
            rd_data[STAT_FLOW_BIT] = flow_mode_q;
            rd_data[STAT_LVL_LSB +: NUM_LINES] = sync_lines;
            rd_data[NUM_LINES-1:0] = delta;
        end
    end

    assign wr_unused = ^{wr_data[DATA_W-1:9], wr_data[7:6], wr_data[4]};

    // R3: pins follow the control write on the next clock
    assert_pins_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((dtr_n == !$past(wr_data[CTRL_DTR_BIT])) &&
                     (rts_n == !$past(wr_data[CTRL_RTS_BIT])) &&
                     (flow_en == $past(wr_data[CTRL_AFC_BIT]))));

    // R9: the event can only appear after a synchronised level moved
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msc_irq) |-> ($past(sync_lines, 1) != $past(sync_lines, 2)));
endmodule

// File: tb/msd_modem_status_tb.sv
`timescale 1ns/1ps
module msd_modem_status_tb;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          cts_in = 1'b1, dsr_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
    logic          dtr_n, rts_n, flow_en, msc_irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    msd_modem_status u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .dtr_n(dtr_n), .rts_n(rts_n), .flow_en(flow_en), .msc_irq(msc_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] rd(input logic [7:0] a);
        rd_addr = a;
        return 32'h0;
    endfunction

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] unused_v;
        unused_v = rd(a);
        #1;
        chk(req, rd_data, exp);
    endtask

    function automatic logic [3:0] lines_now();
        return {dcd_in, ri_in, dsr_in, cts_in};
    endfunction

    function automatic logic [3:0] flags_for(input logic [3:0] o, input logic [3:0] n);
        logic [3:0] f;
        f = o ^ n;
        f[2] = o[2] & ~n[2];
        return f;
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [3:0] exp_f;
        logic       exp_flow;
        void'($urandom(32'h1f3a_5c07));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rdchk("R1 ctrl", 8'h24, 32'h0);
        rdchk("R1 status", 8'h28, 32'h0);
        chk("R1 pins", {dtr_n, rts_n, flow_en, msc_irq}, 4'b1100);
        // R10 CTS high through reset must not flag
        repeat (6) @(negedge clk);
        rdchk("R10 warmup no flag", 8'h28, 32'h10);
        chk("R10 irq", msc_irq, 1'b0);
        // R2 / R3 control register
        wr(8'h24, 32'h23);
        rdchk("R2 ctrl readback", 8'h24, 32'h23);
        chk("R3 pins", {dtr_n, rts_n, flow_en}, 3'b001);
        wr(8'h24, 32'hFFFF_FFFF);
        rdchk("R2 reserved zero", 8'h24, 32'h23);
        wr(8'h24, 32'h01);
        chk("R3 pins dtr only", {dtr_n, rts_n, flow_en}, 3'b010);
        // R11 other offset
        rdchk("R11 other offset", 8'h2C, 32'h0);
        // R4 flow mode, level bits ignore writes
        wr(8'h28, 32'h1F0);
        rdchk("R4 flow bit and levels", 8'h28, 32'h110);
        // R4/R5 timing on DSR
        dsr_in = 1'b1;
        @(negedge clk); @(negedge clk);
        rdchk("R4 level after two edges", 8'h28, 32'h130);
        @(negedge clk);
        rdchk("R5 dsr flag after three edges", 8'h28, 32'h132);
        chk("R9 irq high", msc_irq, 1'b1);
        // R7 zero write keeps, one write clears
        wr(8'h28, 32'h100);
        rdchk("R7 zero write keeps flag", 8'h28, 32'h132);
        wr(8'h28, 32'h102);
        rdchk("R7 clear", 8'h28, 32'h130);
        chk("R9 irq low", msc_irq, 1'b0);
        // R6 ring indicator
        ri_in = 1'b1; settle();
        rdchk("R6 rising ri no flag", 8'h28, 32'h170);
        ri_in = 1'b0; settle();
        rdchk("R6 falling ri flag", 8'h28, 32'h134);
        wr(8'h28, 32'h104);
        // R5 DCD change
        dcd_in = 1'b1; settle();
        rdchk("R5 dcd flag", 8'h28, 32'h1B8);
        wr(8'h28, 32'h108);
        // R8 collision: clear lands on the setting edge
        cts_in = 1'b0;
        @(negedge clk); @(negedge clk);
        wr(8'h28, 32'h101);
        rdchk("R8 set wins", 8'h28, 32'h1A1);
        wr(8'h28, 32'h101);
        rdchk("R8 cleared after", 8'h28, 32'h1A0);
        // randomised rounds against the model
        exp_f = 4'h0; exp_flow = 1'b1;
        for (int it = 0; it < 150; it++) begin
            logic [3:0] o, n, m;
            logic       fb;
            o = lines_now();
            n = 4'($urandom);
            {dcd_in, ri_in, dsr_in, cts_in} = n;
            settle();
            exp_f |= flags_for(o, n);
            rdchk("R5 R6 random flags", 8'h28, {23'h0, exp_flow, n, exp_f});
            chk("R9 random irq", msc_irq, |exp_f);
            m = 4'($urandom);
            fb = 1'($urandom);
            wr(8'h28, {23'h0, fb, 4'($urandom), m});
            exp_f &= ~m; exp_flow = fb;
            rdchk("R7 random clear", 8'h28, {23'h0, exp_flow, n, exp_f});
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule